// File: doc/BRIEF.md
# Page-Mode Pseudo-SRAM Controller

This block connects an internal valid/ready request port to an asynchronous 2M x 16 low-power pseudo-SRAM. It handles single-word reads and writes with a two-bit byte mask, and bursts of up to 16 words. A burst uses the fast in-page access: only the low four address bits change while the chip stays selected. Every analog timing figure is a nanosecond parameter. Each one becomes a whole number of cycles, rounded up, at the configured clock period.

After reset the controller keeps the memory deselected for the power-up interval and accepts no request until that interval ends. During an access it limits how long the chip stays selected without a break. A burst that would run past that limit, or past the end of a 16-word page, is split: the select goes high and the remaining words restart with the full first-word access time. Every deselect lasts at least the minimum high pulse. Write data is taken one word at a time through a take strobe. Read words come back with a one-cycle valid strobe each.

Top module: `psram_page_ctrl`

## Requirements
- R1: After reset is released, `req_ready_o` stays low and `mem_sel_no` and `mem_sel_o` both stay high for ceil(PWRUP_NS/clock) cycles; `req_ready_o` rises once that count has elapsed.
- R2: The memory counts as selected only while `mem_sel_no` is low and `mem_sel_o` is high. Byte-mask bit 1 drives `mem_hi_no` low (bits 15:8) and bit 0 drives `mem_lo_no` low (bits 7:0), only while selected.
- R3: The first word after each select keeps its address and output enable for at least max(tRC, tOE) in cycles before it is sampled. Its data comes out on `rdata_o` with `rdata_valid_o` high for one cycle, and byte lanes that are masked off read as zero.
- R4: Later words of a burst keep the select low. Each one changes only address bits 3:0 and holds its address for at least the page cycle time.
- R5: When a burst would carry out of address bit 3, the controller deselects, continues at the next full address, and applies first-word timing again.
- R6: Each write holds `mem_we_no` low for at least max(tWP, tDS) in cycles with data driven and stable. A recovery cycle with `mem_we_no` high follows before the address changes. Only the masked-in bytes change.
- R7: `wdata_take_o` is high in exactly one cycle per written word. `req_wdata_i` is sampled at that edge, so a burst of n+1 words gives n+1 takes.
- R8: The select never stays low for more than ceil(MAXSEL_NS/clock) consecutive cycles. A longer burst is split into several select periods.
- R9: Each high period of `mem_sel_no` between accesses lasts at least ceil(CP_NS/clock) cycles, and a new request is accepted only after it ends.
- R10: `mem_dq_oe_o` is high only during a write. It is low in the cycle before `mem_oe_no` falls, and `mem_oe_no` and `mem_we_no` are never low together.
- R11: A `req_len_i` value of n moves n+1 words at consecutive addresses, so a read returns exactly n+1 valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| req_addr_i | input | 21 | Start word address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | 2 | Byte mask, bit 1 upper byte, bit 0 lower byte |
| req_len_i | input | 4 | Number of words minus one |
| req_wdata_i | input | 16 | Write data for the current word |
| wdata_take_o | output | 1 | req_wdata_i consumed on this edge |
| rdata_o | output | 16 | Read word |
| rdata_valid_o | output | 1 | rdata_o valid for one cycle |
| mem_addr_o | output | 21 | Memory address |
| mem_sel_no | output | 1 | Memory select, active low |
| mem_sel_o | output | 1 | Memory select, active high |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_hi_no | output | 1 | Upper byte enable, active low |
| mem_lo_no | output | 1 | Lower byte enable, active low |
| mem_dq_o | output | 16 | Data bus drive value |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data bus sampled value |

## Verification
The bench uses a short select limit, so a 16-word burst must split. A controller that ignored the limit would hold the select past it, and the memory model in the bench would flag it. Bursts that start near the end of a page must deselect and apply the long first-word time again. A controller that wrapped within the page, or kept the page timing, would return the wrong words or read too early. A partial-lane read after a partial-lane write expects zeros in the masked lane and the old byte in the untouched lane. That catches a design that wrote both lanes or returned unmasked bus bits. The model also checks the deselect pulse, the power-up hold and the write pulse width, and that the bus is released before output enable.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
package psram_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP, ST_IDLE, ST_RD, ST_WR, ST_WREC, ST_DESEL
  } psram_st_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/psram_timer.sv
`timescale 1ns/1ps
module psram_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= W'(RST_VAL);
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/psram_sel_guard.sv
`timescale 1ns/1ps
// Counts selected cycles; room_o says one more word still fits the cap.
module psram_sel_guard #(
  parameter int unsigned W     = 8,
  parameter int unsigned LIMIT = 100,
  parameter int unsigned GUARD = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic room_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (sel_i)  cnt_q <= cnt_q + 1'b1;
    else             cnt_q <= '0;
  end

  assign room_o = ({1'b0, cnt_q} + (W+1)'(GUARD)) <= (W+1)'(LIMIT);
endmodule

// File: rtl/psram_page_ctrl.sv
`timescale 1ns/1ps
module psram_page_ctrl
  import psram_pkg::*;
#(
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned PWRUP_NS  = 200000,
  parameter int unsigned RC_NS     = 70,
  parameter int unsigned PC_NS     = 25,
  parameter int unsigned OE_NS     = 25,
  parameter int unsigned WP_NS     = 50,
  parameter int unsigned DS_NS     = 20,
  parameter int unsigned MAXSEL_NS = 20000,
  parameter int unsigned CP_NS     = 5,
  parameter int unsigned AW        = 21,
  parameter int unsigned PAGE_BITS = 4,
  parameter int unsigned LEN_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_addr_i,
  input  logic             req_we_i,
  input  logic [1:0]       req_be_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [15:0]      req_wdata_i,
  output logic             wdata_take_o,
  output logic [15:0]      rdata_o,
  output logic             rdata_valid_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_sel_no,
  output logic             mem_sel_o,
  output logic             mem_oe_no,
  output logic             mem_we_no,
  output logic             mem_hi_no,
  output logic             mem_lo_no,
  output logic [15:0]      mem_dq_o,
  output logic             mem_dq_oe_o,
  input  logic [15:0]      mem_dq_i
);
  localparam int unsigned PU_C    = umax(ns2cyc(PWRUP_NS, CLK_PS), 1);
  localparam int unsigned RDF_C   = umax(umax(ns2cyc(RC_NS, CLK_PS), ns2cyc(OE_NS, CLK_PS)), 1);
  localparam int unsigned RDP_C   = umax(ns2cyc(PC_NS, CLK_PS), 1);
  localparam int unsigned WR_C    = umax(umax(ns2cyc(WP_NS, CLK_PS), ns2cyc(DS_NS, CLK_PS)), 1);
  localparam int unsigned CP_C    = umax(ns2cyc(CP_NS, CLK_PS), 1);
  localparam int unsigned SEL_C   = ns2cyc(MAXSEL_NS, CLK_PS);
  localparam int unsigned GUARD_C = umax(RDP_C, WR_C + 1) + 1;
  localparam int unsigned TW      = $clog2(PU_C + RDF_C + WR_C + CP_C + 1);
  localparam int unsigned SW      = $clog2(SEL_C + GUARD_C + 1) + 1;

  psram_st_e            st_q, st_d;
  logic [AW-1:0]        addr_q, addr_d;
  logic [LEN_W-1:0]     left_q, left_d;
  logic [15:0]          wdat_q, wdat_d;
  logic [1:0]           be_q, be_d;
  logic                 we_q, we_d, pend_q, pend_d;
  logic                 t_load, t_done, take, cap, room, sel_act, page_last;
  logic [TW-1:0]        t_val;
  logic [15:0]          rdata_q;
  logic                 rvalid_q;

  psram_timer #(.W(TW), .RST_VAL(PU_C - 1)) u_timer (
    .clk_i, .rst_ni, .load_i(t_load), .load_val_i(t_val), .done_o(t_done)
  );

  psram_sel_guard #(.W(SW), .LIMIT(SEL_C), .GUARD(GUARD_C)) u_guard (
    .clk_i, .rst_ni, .sel_i(sel_act), .room_o(room)
  );

  assign sel_act   = (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_WREC);
  assign page_last = &addr_q[PAGE_BITS-1:0];

  always_comb begin
    st_d   = st_q;   addr_d = addr_q; left_d = left_q; wdat_d = wdat_q;
    be_d   = be_q;   we_d   = we_q;   pend_d = pend_q;
    t_load = 1'b0;   t_val  = '0;     take   = 1'b0;   cap = 1'b0;
    unique case (st_q)
      ST_PWRUP: if (t_done) st_d = ST_IDLE;
      ST_IDLE: if (req_valid_i) begin
        addr_d = req_addr_i; we_d = req_we_i; be_d = req_be_i;
        left_d = req_len_i;  wdat_d = req_wdata_i; take = req_we_i;
        t_load = 1'b1;
        t_val  = req_we_i ? TW'(WR_C - 1) : TW'(RDF_C - 1);
        st_d   = req_we_i ? ST_WR : ST_RD;
      end
      ST_RD: if (t_done) begin
        cap = 1'b1;
        if (left_q == '0) begin
          st_d = ST_DESEL; pend_d = 1'b0; t_load = 1'b1; t_val = TW'(CP_C - 1);
        end else begin
          addr_d = addr_q + 1'b1; left_d = left_q - 1'b1;
          t_load = 1'b1;
          if (page_last || !room) begin
            st_d = ST_DESEL; pend_d = 1'b1; t_val = TW'(CP_C - 1);
          end else begin
            t_val = TW'(RDP_C - 1);
          end
        end
      end
      ST_WR: if (t_done) st_d = ST_WREC;
      ST_WREC: begin
        t_load = 1'b1;
        if (left_q == '0) begin
          st_d = ST_DESEL; pend_d = 1'b0; t_val = TW'(CP_C - 1);
        end else begin
          take = 1'b1; wdat_d = req_wdata_i;
          addr_d = addr_q + 1'b1; left_d = left_q - 1'b1;
          if (page_last || !room) begin
            st_d = ST_DESEL; pend_d = 1'b1; t_val = TW'(CP_C - 1);
          end else begin
            st_d = ST_WR; t_val = TW'(WR_C - 1);
          end
        end
      end
      ST_DESEL: if (t_done) begin
        if (pend_q) begin
          // restart after a split with full first-word timing
          t_load = 1'b1;
          t_val  = we_q ? TW'(WR_C - 1) : TW'(RDF_C - 1);
          st_d   = we_q ? ST_WR : ST_RD;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_PWRUP; addr_q <= '0; left_q <= '0; wdat_q <= '0;
      be_q <= '0; we_q <= 1'b0; pend_q <= 1'b0;
      rdata_q <= '0; rvalid_q <= 1'b0;
    end else begin
      st_q <= st_d; addr_q <= addr_d; left_q <= left_d; wdat_q <= wdat_d;
      be_q <= be_d; we_q <= we_d; pend_q <= pend_d;
      rvalid_q <= cap;
      if (cap) rdata_q <= mem_dq_i & {{8{be_q[1]}}, {8{be_q[0]}}};
    end
  end

  assign req_ready_o   = (st_q == ST_IDLE);
  assign wdata_take_o  = take;
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvalid_q;
  assign mem_addr_o    = addr_q;
  assign mem_sel_no    = !sel_act;
  assign mem_sel_o     = 1'b1;
  assign mem_oe_no     = (st_q != ST_RD);
  assign mem_we_no     = (st_q != ST_WR);
  assign mem_hi_no     = !(sel_act && be_q[1]);
  assign mem_lo_no     = !(sel_act && be_q[0]);
  assign mem_dq_o      = wdat_q;
  assign mem_dq_oe_o   = (st_q == ST_WR) || (st_q == ST_WREC);
endmodule

// File: rtl/psram_page_ctrl_chk.sv
`timescale 1ns/1ps
module psram_page_ctrl_chk
  import psram_pkg::*;
#(
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned PWRUP_NS  = 200000,
  parameter int unsigned WP_NS     = 50,
  parameter int unsigned MAXSEL_NS = 20000,
  parameter int unsigned CP_NS     = 5,
  parameter int unsigned AW        = 21,
  parameter int unsigned PAGE_BITS = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rdata_valid_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_sel_no,
  input logic          mem_sel_o,
  input logic          mem_oe_no,
  input logic          mem_we_no,
  input logic          mem_dq_oe_o
);
  localparam int unsigned PU_C  = umax(ns2cyc(PWRUP_NS, CLK_PS), 1);
  localparam int unsigned WP_C  = ns2cyc(WP_NS, CLK_PS);
  localparam int unsigned SEL_C = ns2cyc(MAXSEL_NS, CLK_PS);
  localparam int unsigned CP_C  = umax(ns2cyc(CP_NS, CLK_PS), 1);

  int unsigned pu_cnt, sel_run, hi_run, we_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pu_cnt <= 0; sel_run <= 0; hi_run <= 0; we_run <= 0;
    end else begin
      if (pu_cnt < PU_C) pu_cnt <= pu_cnt + 1;
      sel_run <= mem_sel_no ? 0 : sel_run + 1;
      hi_run  <= !mem_sel_no ? 0 : ((hi_run < CP_C) ? hi_run + 1 : hi_run);
      we_run  <= mem_we_no ? 0 : we_run + 1;
    end
  end

  assert_pwrup_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_cnt < PU_C) |-> (mem_sel_no && mem_sel_o && !req_ready_o));
  assert_sel_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_sel_no |-> (sel_run < SEL_C));
  assert_desel_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_sel_no) |-> (hi_run >= CP_C));
  assert_page_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_sel_no && $past(!mem_sel_no)) |-> $stable(mem_addr_o[AW-1:PAGE_BITS]));
  assert_we_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (we_run >= WP_C));
  assert_read_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> $past(!mem_oe_no));
  assert_bus_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_oe_no) |-> !$past(mem_dq_oe_o));
  assert_no_oe_we_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));
endmodule

bind psram_page_ctrl psram_page_ctrl_chk #(
  .CLK_PS(CLK_PS), .PWRUP_NS(PWRUP_NS), .WP_NS(WP_NS), .MAXSEL_NS(MAXSEL_NS),
  .CP_NS(CP_NS), .AW(AW), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .rdata_valid_o(rdata_valid_o), .mem_addr_o(mem_addr_o),
  .mem_sel_no(mem_sel_no), .mem_sel_o(mem_sel_o), .mem_oe_no(mem_oe_no),
  .mem_we_no(mem_we_no), .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/psram_page_ctrl_tb.sv
`timescale 1ns/1ps
module psram_page_ctrl_tb;
  // cycle figures at 4 ns, worked out by hand from the requirements
  localparam int PU_C = 1000, RDF_C = 18, RDP_C = 7, WP_C = 13, CP_C = 2, SEL_C = 50;
  localparam int NV = 13;
  // {we, be[1:0], len[3:0], addr[20:0], data[15:0], min select periods[1:0]}
  localparam logic [45:0] VEC [NV] = '{
    {1'b1, 2'd3, 4'd0,  21'h000010, 16'h1234, 2'd1},
    {1'b0, 2'd3, 4'd0,  21'h000010, 16'h0000, 2'd1},
    {1'b1, 2'd1, 4'd0,  21'h000010, 16'hABCD, 2'd1},
    {1'b0, 2'd2, 4'd0,  21'h000010, 16'h0000, 2'd1},
    {1'b0, 2'd3, 4'd0,  21'h000010, 16'h0000, 2'd1},
    {1'b1, 2'd3, 4'd3,  21'h000020, 16'h1000, 2'd1},
    {1'b0, 2'd3, 4'd3,  21'h000020, 16'h0000, 2'd1},
    {1'b1, 2'd3, 4'd3,  21'h00002E, 16'h5000, 2'd2},
    {1'b0, 2'd3, 4'd7,  21'h00002C, 16'h0000, 2'd2},
    {1'b1, 2'd3, 4'd15, 21'h000040, 16'h7000, 2'd2},
    {1'b0, 2'd3, 4'd15, 21'h000040, 16'h0000, 2'd2},
    {1'b1, 2'd2, 4'd0,  21'h000045, 16'hEE00, 2'd1},
    {1'b0, 2'd3, 4'd0,  21'h000045, 16'h0000, 2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_we = 0, req_ready, wtake, rvalid;
  logic [20:0] req_addr = '0, mem_addr;
  logic [1:0]  req_be = '0;
  logic [3:0]  req_len = '0;
  logic [15:0] req_wdata, rdata, mem_dq_o, mem_dq_i = '0;
  logic sel_no, sel_o, oe_n, we_n, hi_n, lo_n, dq_oe;

  always #2 clk = ~clk;

  psram_page_ctrl #(.PWRUP_NS(4000), .MAXSEL_NS(200)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_be_i(req_be), .req_len_i(req_len),
    .req_wdata_i(req_wdata), .wdata_take_o(wtake), .rdata_o(rdata), .rdata_valid_o(rvalid),
    .mem_addr_o(mem_addr), .mem_sel_no(sel_no), .mem_sel_o(sel_o), .mem_oe_no(oe_n),
    .mem_we_no(we_n), .mem_hi_no(hi_n), .mem_lo_no(lo_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write data source
  logic [15:0] wbuf [0:15];
  int widx = 0, takes = 0;
  assign req_wdata = wbuf[widx[3:0]];
  always @(posedge clk) if (wtake) begin widx <= widx + 1; takes <= takes + 1; end

  // memory model, evaluated away from the active edge
  logic [15:0] mem [int];
  int v_sel = 0, v_desel = 0, v_pu = 0, v_rd = 0, v_page = 0, v_wr = 0, v_bus = 0;
  int episodes = 0, cyc = 0, sel_len = 0, desel_len = 0, phase_len = 0, we_len = 0;
  bit saw_hi = 0, saw_lo = 0, prev_sel = 0, prev_rd = 0, prev_wl = 0, first_ph = 0;
  logic prev_oe_n = 1, prev_dq_oe = 0, prev_hi_n = 1, prev_lo_n = 1;
  logic [20:0] prev_addr = '0;
  logic [15:0] prev_dq = '0;

  function automatic logic [15:0] peek(input logic [20:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    bit s, rd;
    logic [15:0] w;
    if (rst_n) begin
      cyc++;
      s  = !sel_no && sel_o;
      rd = s && !oe_n;
      if (!oe_n && !we_n) v_bus++;
      if (!oe_n && prev_oe_n && prev_dq_oe) v_bus++;
      if (dq_oe && !s) v_bus++;
      if (s) begin
        if (!prev_sel) begin
          episodes++; first_ph = 1; phase_len = 0;
          if (cyc <= PU_C) v_pu++;
          if (desel_len < CP_C) v_desel++;
        end
        sel_len++;
        if (sel_len > SEL_C) v_sel++;
        if (prev_sel && mem_addr[20:4] != prev_addr[20:4]) v_page++;
        if (!hi_n) saw_hi = 1;
        if (!lo_n) saw_lo = 1;
        desel_len = 0;
      end else begin
        sel_len = 0; desel_len++;
      end
      if (prev_rd && (!rd || mem_addr != prev_addr)) begin
        if (phase_len < (first_ph ? RDF_C : RDP_C)) v_rd++;
        first_ph = 0; phase_len = 0;
      end
      if (rd) phase_len++;
      if (s && !we_n) begin
        we_len++;
        if (!dq_oe) v_wr++;
        if (prev_wl && mem_dq_o != prev_dq) v_wr++;
      end
      if (prev_wl && (we_n || !s)) begin
        if (we_len < WP_C) v_wr++;
        w = peek(prev_addr);
        if (!prev_hi_n) w[15:8] = prev_dq[15:8];
        if (!prev_lo_n) w[7:0]  = prev_dq[7:0];
        mem[int'(prev_addr)] = w;
        we_len = 0;
      end
      w = peek(mem_addr);
      mem_dq_i <= rd ? {hi_n ? 8'hA5 : w[15:8], lo_n ? 8'h5A : w[7:0]} : 16'h0000;
      prev_sel = s; prev_rd = rd; prev_wl = s && !we_n; prev_addr = mem_addr;
      prev_dq = mem_dq_o; prev_oe_n = oe_n; prev_dq_oe = dq_oe;
      prev_hi_n = hi_n; prev_lo_n = lo_n;
    end
  end

  // read capture
  logic [15:0] rq [0:31];
  int rn = 0;
  always @(negedge clk) if (rst_n && rvalid) begin rq[rn[4:0]] <= rdata; rn <= rn + 1; end

  // bench's own view of memory contents
  logic [15:0] shadow [int];
  function automatic logic [15:0] sh(input logic [20:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
  endfunction

  task automatic run_op(input logic [45:0] v);
    logic        we;
    logic [1:0]  be;
    logic [3:0]  len;
    logic [20:0] a;
    logic [15:0] d, e, s;
    int ep0, n, guard;
    we = v[45]; be = v[44:43]; len = v[42:39]; a = v[38:18]; d = v[17:2];
    for (int k = 0; k < 16; k++) wbuf[k] = d + 16'(k) * 16'h0101;
    guard = 0;
    while (!req_ready && guard < 5000) begin @(negedge clk); guard++; end
    widx = 0; takes = 0; rn = 0; saw_hi = 0; saw_lo = 0; ep0 = episodes;
    req_valid = 1; req_we = we; req_be = be; req_len = len; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    guard = 0;
    while (!req_ready && guard < 5000) begin @(negedge clk); guard++; end
    check(guard < 5000, "R9 op completes", 32'(guard), 32'd0);
    check(sel_no == 1'b1, "R2 idle deselected", 32'(sel_no), 32'd1);
    n = int'(len) + 1;
    if (we) begin
      check(takes == n, "R7 write data takes", 32'(takes), 32'(n));
      for (int k = 0; k < n; k++) begin
        s = sh(a + 21'(k));
        if (be[1]) s[15:8] = wbuf[k][15:8];
        if (be[0]) s[7:0]  = wbuf[k][7:0];
        shadow[int'(a + 21'(k))] = s;
      end
    end else begin
      check(rn == n, "R11 read word count", 32'(rn), 32'(n));
      for (int k = 0; k < n && k < rn; k++) begin
        s = sh(a + 21'(k));
        e = {be[1] ? s[15:8] : 8'h00, be[0] ? s[7:0] : 8'h00};
        check(rq[k] == e, (len == 0) ? "R3 read word" : "R4 page word", 32'(rq[k]), 32'(e));
      end
      if (be == 2'd2) check(saw_hi && !saw_lo, "R2 lane enables", {30'd0, saw_hi, saw_lo}, 32'd2);
    end
    if (v[1:0] > 2'd1)
      check((episodes - ep0) >= int'(v[1:0]), (a[3:0] == 4'hE || a[3:0] == 4'hC) ? "R5 page crossing split" : "R8 select cap split",
            32'(episodes - ep0), 32'(v[1:0]));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check(req_ready == 0, "R1 reset ready", 32'(req_ready), 32'd0);
    check(sel_no == 1 && sel_o == 1, "R1 reset selects", {30'd0, sel_no, sel_o}, 32'd3);
    check(dq_oe == 0 && rvalid == 0, "R10 reset bus", {30'd0, dq_oe, rvalid}, 32'd0);
    rst_n = 1;
    cnt = 0;
    while (!req_ready && cnt < 3000) begin
      @(negedge clk); cnt++;
      if (!req_ready && (sel_no != 1 || sel_o != 1)) check(0, "R1 select during power-up", 32'(sel_no), 32'd1);
    end
    check(cnt >= PU_C && cnt <= PU_C + 2, "R1 power-up length", 32'(cnt), 32'(PU_C));
    for (int i = 0; i < NV; i++) run_op(VEC[i]);
    // directed: 16-word burst from page start, fully masked lanes written back
    run_op({1'b1, 2'd3, 4'd15, 21'h1FFFF0, 16'h0102, 2'd2});
    run_op({1'b0, 2'd1, 4'd15, 21'h1FFFF0, 16'h0000, 2'd2});
    repeat (5) @(negedge clk);
    check(v_pu == 0,    "R1 model power-up",      32'(v_pu),    32'd0);
    check(v_rd == 0,    "R3 model read timing",   32'(v_rd),    32'd0);
    check(v_page == 0,  "R4 model page address",  32'(v_page),  32'd0);
    check(v_wr == 0,    "R6 model write pulse",   32'(v_wr),    32'd0);
    check(v_sel == 0,   "R8 model select time",   32'(v_sel),   32'd0);
    check(v_desel == 0, "R9 model deselect",      32'(v_desel), 32'd0);
    check(v_bus == 0,   "R10 model bus usage",    32'(v_bus),   32'd0);
    summary();
  end
endmodule